// File: doc/BRIEF.md
# Circular Buffer Readout Sequencer

This block drains a circular sample memory in time order once capture has finished. The capture controller raises a read enable together with the address that holds the oldest sample of the window. The sequencer turns that window into linear bursts for a downstream bus master. Each burst is a start address and a word count. The first burst runs from the given address up to the top of memory. If the window wraps, a second burst covers the bottom of memory up to the word just below the start address.

Each burst is announced with a one-cycle request while its address and length are driven. The sequencer then waits for the master's acknowledge. After the last acknowledge it sends a one-cycle done pulse back to the capture controller and becomes idle again. While a readout is in progress, further read enables and acknowledges that arrive outside a wait are dropped.

Top module: `circ_readout_seq`

## Requirements
- R1: After reset, `burstReq` and `readDone` are 0 and stay 0 until a read enable is seen.
- R2: When `readEn` is sampled high while idle, `burstReq` pulses in the next cycle with `burstAddr` = start address S and `burstLen` = DEPTH − S.
- R3: When S ≠ 0, the second request is issued in the cycle after the first burst's acknowledge is sampled, never earlier, with `burstAddr` = 0 and `burstLen` = S.
- R4: When S = 0 there is exactly one burst (address 0, length DEPTH), and no second request is made.
- R5: `readDone` is a single-cycle pulse in the cycle after the final burst's acknowledge is sampled.
- R6: A `readEn` that arrives while a readout is in progress is ignored: the start address in use stays the same and no extra request is made.
- R7: `burstAck` has no effect unless the sequencer is waiting on an issued burst.
- R8: The bursts of one readout together cover DEPTH addresses exactly once, in chronological order: first S..DEPTH−1, then 0..S−1.
- R9: `burstReq` lasts one cycle per burst, and `burstAddr`/`burstLen` hold steady until that burst's acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readEn | input | 1 | Readout command from the capture controller |
| startAddr | input | ADDR_W | Address of the oldest sample, sampled with `readEn` |
| burstReq | output | 1 | One-cycle command to the bus master to start a burst |
| burstAddr | output | ADDR_W | First address of the current burst |
| burstLen | output | LEN_W | Word count of the current burst (1..DEPTH) |
| burstAck | input | 1 | Master completion acknowledge for the current burst |
| readDone | output | 1 | One-cycle completion pulse to the capture controller |

## Verification
The bench targets start addresses 0, DEPTH/2 and DEPTH−1, plus random addresses and random acknowledge delays. Getting the wrap point wrong shows up as a second burst when S = 0, a length off by one, or the halves in swapped order. A stray `readEn` is held high during the waits with a different address. A design that reloaded it would move the second burst or restart the sequence. Acknowledges sent while idle would be accepted by a design that does not check its state, and that design would then pulse `readDone` or issue a request without any read enable.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef struct packed {
    logic load;    // capture start address
    logic issue;   // burst request cycle
    logic second;  // wrapped (low) burst selected
    logic finish;  // completion cycle
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE1, ST_WAIT1, ST_ISSUE2, ST_WAIT2, ST_FINISH
  } seqState_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         readEn,
  input  logic         burstAck,
  input  logic         wraps,
  output ctrlStrobes_t strb
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (readEn) nextState = ST_ISSUE1;
      ST_ISSUE1: nextState = ST_WAIT1;
      ST_WAIT1:  if (burstAck) nextState = wraps ? ST_ISSUE2 : ST_FINISH;
      ST_ISSUE2: nextState = ST_WAIT2;
      ST_WAIT2:  if (burstAck) nextState = ST_FINISH;
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load   = (state == ST_IDLE) && readEn;
    strb.issue  = (state == ST_ISSUE1) || (state == ST_ISSUE2);
    strb.second = (state == ST_ISSUE2) || (state == ST_WAIT2);
    strb.finish = (state == ST_FINISH);
  end

  // R5: completion lasts exactly one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !strb.finish);
  // R9: a request is never held across two cycles
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> !strb.issue);
  // R3: the low burst only follows an acknowledged first burst
  a_r3_second_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.second) |-> $past(state == ST_WAIT1) && $past(burstAck));
  // R6: a new sequence only starts from idle
  a_r6_start_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ISSUE1) |-> $past(state == ST_IDLE) && $past(readEn));
endmodule

// File: rtl/rcs_path.sv
module rcs_path
  import rcs_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 9
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              wraps,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DEPTH);

  logic [ADDR_W-1:0] startReg;

  always_ff @(posedge clk) begin
    if (!rstN)          startReg <= '0;
    else if (strb.load) startReg <= startAddr;
  end

  always_comb begin
    wraps = (startReg != '0);
    if (strb.second) begin
      burstAddr = '0;
      burstLen  = LEN_W'(startReg);
    end else begin
      burstAddr = startReg;
      burstLen  = FULL_LEN - LEN_W'(startReg);
    end
  end

  // R2: every issued burst has a length in 1..DEPTH
  a_r2_len_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (burstLen != '0) && (burstLen <= FULL_LEN));
  // R9: burst description is steady while waiting on the master
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue || $past(strb.issue)) && !strb.issue && !strb.finish && !$rose(strb.second)
      |-> $stable(burstAddr) && $stable(burstLen));
endmodule

// File: rtl/circ_readout_seq.sv
module circ_readout_seq
  import rcs_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              readEn,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              burstReq,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen,
  input  logic              burstAck,
  output logic              readDone
);
  ctrlStrobes_t strb;
  logic         wraps;

  rcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .readEn(readEn), .burstAck(burstAck),
    .wraps(wraps), .strb(strb)
  );

  rcs_path #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .wraps(wraps), .burstAddr(burstAddr), .burstLen(burstLen)
  );

  assign burstReq = strb.issue;
  assign readDone = strb.finish;

  // R4: no second burst without wrap
  a_r4_single_burst: assert property (@(posedge clk) disable iff (!rstN)
    (burstReq && burstAddr == '0 && burstLen == LEN_W'(DEPTH)) |=> ##1 !burstReq);
endmodule

// File: tb/circ_readout_seq_tb.sv
module circ_readout_seq_tb;
  localparam int DEPTH  = 256;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 9;

  logic clk = 0;
  logic rstN = 0;
  logic readEn = 0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic burstReq, readDone, burstAck = 0;
  logic [ADDR_W-1:0] burstAddr;
  logic [LEN_W-1:0] burstLen;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  circ_readout_seq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .readEn(readEn), .startAddr(startAddr),
    .burstReq(burstReq), .burstAddr(burstAddr), .burstLen(burstLen),
    .burstAck(burstAck), .readDone(readDone)
  );

  function automatic int firstLen(int s);  return DEPTH - s; endfunction
  function automatic int secondLen(int s); return s;         endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R7: ack while idle must do nothing
  task automatic strayAck();
    @(negedge clk) burstAck = 1;
    @(negedge clk) burstAck = 0;
    chk("R7 idle ack req", burstReq, 0);
    chk("R7 idle ack done", readDone, 0);
    @(negedge clk);
    chk("R7 idle ack req later", burstReq, 0);
  endtask

  task automatic waitAck(int dly, bit noise, int s);
    for (int i = 0; i < dly; i++) begin
      if (noise) begin readEn = 1; startAddr = ADDR_W'(s ^ 8'h5A); end
      @(negedge clk);
      chk("R9 no req while waiting", burstReq, 0);
      chk("R5 no done while waiting", readDone, 0);
    end
    readEn = 0;
    burstAck = 1;
    @(negedge clk) burstAck = 0;
  endtask

  task automatic readout(int s, int d1, int d2, bit noise);
    int total;
    @(negedge clk);
    readEn = 1; startAddr = ADDR_W'(s);
    @(negedge clk);
    readEn = 0;
    chk("R2 first req", burstReq, 1);
    chk("R2 first addr", burstAddr, s);
    chk("R2 first len", burstLen, firstLen(s));
    total = burstLen;
    waitAck(d1, noise, s);
    if (s != 0) begin
      chk("R3 second req", burstReq, 1);
      chk("R3 second addr", burstAddr, 0);
      chk("R3 second len", burstLen, secondLen(s));
      chk("R6 done not early", readDone, 0);
      total += burstLen;
      waitAck(d2, noise, s);
    end else begin
      chk("R4 no second req", burstReq, 0);
    end
    chk("R5 done pulse", readDone, 1);
    chk("R8 total len", total, DEPTH);
    @(negedge clk);
    chk("R5 done one cycle", readDone, 0);
    chk("R6 no restart", burstReq, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset req", burstReq, 0);
    chk("R1 reset done", readDone, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle req", burstReq, 0);
    strayAck();
    readout(0, 1, 1, 0);
    readout(DEPTH / 2, 2, 3, 0);
    readout(DEPTH - 1, 1, 1, 1);
    readout(1, 3, 1, 1);
    readout(0, 2, 1, 1);
    strayAck();
    for (int n = 0; n < 40; n++)
      readout(int'($urandom_range(DEPTH - 1, 0)), int'($urandom_range(5, 1)),
              int'($urandom_range(5, 1)), bit'($urandom_range(1, 0)));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule